// File: doc/BRIEF.md
# SHA-2 Two-Round Vector Compression Unit

This unit runs the vector form of the SHA-2 compression step over element groups of four. Each group supplies three four-element operands. The first holds half of the working state {a,b,e,f}. The old destination holds the other half {c,d,g,h}. The third is a group of message-schedule words. The unit runs two SHA-2 rounds and returns the new {a,b,e,f} half as the destination group. A width input selects 32-bit elements (SHA-256 rounds) or 64-bit elements (SHA-512 rounds). A word-select input picks the lower or the upper pair of schedule words.

A sequencer drives the operation after a start pulse. It walks from the group that holds the start element up to the last complete group below the vector length, at one group per clock. The operand groups are read combinationally at the group index it presents. A vector length that is not a multiple of four is rejected with an illegal flag, and nothing is written. If the tail policy is agnostic, the sequencer then writes all-ones elements from the vector length up to the element capacity, one per cycle. A one-cycle done pulse ends the operation. That pulse also tells the surrounding logic to clear its start index, unless the operation was rejected.

Top module: `sha2_vcompress`

## Requirements
- R1: In 32-bit mode, every written group is the result of two SHA-256 rounds. The operands are loaded as a=src2[3], b=src2[2], e=src2[1], f=src2[0], c=dst[3], d=dst[2], g=dst[1], h=dst[0]. Σ0 rotates right by 2, 13 and 22, Σ1 rotates right by 6, 11 and 25, and all sums wrap modulo 2^32. The second round uses the values produced by the first.
- R2: In 64-bit mode, Σ0 rotates right by 28, 34 and 39 and Σ1 rotates right by 14, 18 and 41. Sums wrap modulo 2^64.
- R3: With the word-select low (hi_words=0), the two rounds consume schedule lanes 0 and then 1. With it high, they consume lanes 2 and then 3.
- R4: The written group carries lane0=f, lane1=e, lane2=b and lane3=a, taken from the state after the second round.
- R5: If vl is not a multiple of four, done and illegal both rise in the cycle after start. No group write and no tail write happens, and vstart_clr stays low.
- R6: Groups are written one per cycle, with grp_idx running from vstart/4 up to vl/4-1 in increasing order. No group is written when vstart/4 >= vl/4.
- R7: With tail_agn=1, after the last group the elements vl through cap-1 are written one per cycle in increasing order of tail_idx, with tail_data all ones. With tail_agn=0, no tail write happens.
- R8: busy is high during every group or tail write cycle. done is a single-cycle pulse in the cycle after the last write, and vstart_clr pulses with it on a legal operation.
- R9: While reset is held and right after it is released, busy, done, illegal, wr_en and tail_en are all low.
- R10: In 32-bit mode, the upper 32 bits of every written lane and of tail_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| sew64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| hi_words | input | 1 | 1: schedule lanes 2 and 3, 0: lanes 0 and 1 |
| tail_agn | input | 1 | Tail-agnostic policy: fill the tail with ones |
| vl | input | IW | Vector length in elements |
| vstart | input | IW | First element to process |
| cap | input | IW | Element capacity of the destination |
| src2_grp | input | 4*64 | {a,b,e,f} group at grp_idx, lane k at bits 64k+63:64k |
| dst_grp | input | 4*64 | Old {c,d,g,h} group at grp_idx |
| sched_grp | input | 4*64 | Schedule group at grp_idx |
| busy | output | 1 | Writing groups or tail |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Pulses with done when vl is rejected |
| vstart_clr | output | 1 | Pulses with done on legal completion |
| grp_idx | output | IW-2 | Group being processed |
| wr_en | output | 1 | Write wr_data to the group at grp_idx |
| wr_data | output | 4*64 | New {a,b,e,f} group |
| tail_en | output | 1 | Write tail_data to element tail_idx |
| tail_idx | output | IW | Tail element index |
| tail_data | output | 64 | All-ones fill value at the element width |

## Verification
Each operation's operands are drawn at random, so a wrong rotation amount, a swapped operand lane or a first-round value reused in the second round shows up as a data mismatch. Width and word-select are tried in all four pairings, which tells the two sets of Σ constants and the two schedule halves apart. Start offsets of zero, nonzero and at or past the last group separate correct range limits from off-by-one stepping. Tail-agnostic and tail-undisturbed runs, capacities that are and are not multiples of four, and a rejected length separate fill, no-fill and no-write behaviour.

// File: rtl/sha2vc_pkg.sv
package sha2vc_pkg;
  localparam int LW    = 64;   // lane width (widest element)
  localparam int NLANE = 4;    // elements per group
  localparam int NRND  = 2;    // rounds per group

  typedef struct packed {
    logic [LW-1:0] a, b, c, d, e, f, g, h;
  } wstate_t;

  // rotate right at either element width; narrow result is zero-extended
  function automatic logic [LW-1:0] rotr(input logic [LW-1:0] x, input int unsigned n,
                                         input logic wide);
    logic [2*LW-1:0] dbl;
    if (wide) begin
      dbl = {x, x} >> n;
    end else begin
      dbl = {{LW{1'b0}}, x[LW/2-1:0], x[LW/2-1:0]} >> n;
      dbl[2*LW-1:LW/2] = '0;
    end
    return dbl[LW-1:0];
  endfunction

  function automatic logic [LW-1:0] bsig0(input logic [LW-1:0] x, input logic wide);
    if (wide) return rotr(x, 28, 1'b1) ^ rotr(x, 34, 1'b1) ^ rotr(x, 39, 1'b1);
    return rotr(x, 2, 1'b0) ^ rotr(x, 13, 1'b0) ^ rotr(x, 22, 1'b0);
  endfunction

  function automatic logic [LW-1:0] bsig1(input logic [LW-1:0] x, input logic wide);
    if (wide) return rotr(x, 14, 1'b1) ^ rotr(x, 18, 1'b1) ^ rotr(x, 41, 1'b1);
    return rotr(x, 6, 1'b0) ^ rotr(x, 11, 1'b0) ^ rotr(x, 25, 1'b0);
  endfunction
endpackage

// File: rtl/sha2_round.sv
module sha2_round
  import sha2vc_pkg::*;
(
  input  logic          wide,
  input  wstate_t       s_in,
  input  logic [LW-1:0] w,
  output wstate_t       s_out
);
  logic [LW-1:0] mask, choose, major, t1, t2;

  always_comb begin
    mask   = wide ? {LW{1'b1}} : {{(LW/2){1'b0}}, {(LW/2){1'b1}}};
    choose = (s_in.e & s_in.f) ^ (~s_in.e & s_in.g);
    major  = (s_in.a & s_in.b) ^ (s_in.a & s_in.c) ^ (s_in.b & s_in.c);
    t1     = (s_in.h + bsig1(s_in.e, wide) + choose + w) & mask;
    t2     = (bsig0(s_in.a, wide) + major) & mask;
    s_out.a = (t1 + t2) & mask;
    s_out.b = s_in.a;
    s_out.c = s_in.b;
    s_out.d = s_in.c;
    s_out.e = (s_in.d + t1) & mask;
    s_out.f = s_in.e;
    s_out.g = s_in.f;
    s_out.h = s_in.g;
  end
endmodule

// File: rtl/sha2_two_round.sv
module sha2_two_round
  import sha2vc_pkg::*;
(
  input  logic                wide,
  input  logic                hi_sel,
  input  logic [NLANE*LW-1:0] half_abef,
  input  logic [NLANE*LW-1:0] half_cdgh,
  input  logic [NLANE*LW-1:0] sched,
  output logic [NLANE*LW-1:0] result
);
  logic [LW-1:0] mask;
  logic [LW-1:0] x [NLANE];
  logic [LW-1:0] y [NLANE];
  logic [LW-1:0] s [NLANE];
  wstate_t       chain [NRND+1];

  assign mask = wide ? {LW{1'b1}} : {{(LW/2){1'b0}}, {(LW/2){1'b1}}};

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign x[k] = half_abef[k*LW +: LW] & mask;
    assign y[k] = half_cdgh[k*LW +: LW] & mask;
    assign s[k] = sched[k*LW +: LW] & mask;
  end

  always_comb begin
    chain[0].a = x[3];
    chain[0].b = x[2];
    chain[0].e = x[1];
    chain[0].f = x[0];
    chain[0].c = y[3];
    chain[0].d = y[2];
    chain[0].g = y[1];
    chain[0].h = y[0];
  end

  for (genvar r = 0; r < NRND; r++) begin : g_rnd
    logic [LW-1:0] w_sel;
    assign w_sel = hi_sel ? s[NRND + r] : s[r];
    sha2_round u_round (
      .wide  (wide),
      .s_in  (chain[r]),
      .w     (w_sel),
      .s_out (chain[r+1])
    );
  end

  assign result = {chain[NRND].a, chain[NRND].b, chain[NRND].e, chain[NRND].f};
endmodule

// File: rtl/sha2_seq.sv
module sha2_seq #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wide_in,
  input  logic          hi_in,
  input  logic          agn_in,
  input  logic [IW-1:0] vl,
  input  logic [IW-1:0] vstart,
  input  logic [IW-1:0] cap,
  output logic          wide_q,
  output logic          hi_q,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic          clr_vstart,
  output logic          grp_en,
  output logic [IW-3:0] grp_idx,
  output logic          tail_en,
  output logic [IW-1:0] tail_idx
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FILL, S_FIN} st_t;

  st_t           st_q, st_d;
  logic [IW-1:0] cnt_q, cnt_d, vl_q, vl_d, cap_q, cap_d;
  logic          agn_q, agn_d, err_q, err_d, wide_d, hi_d;
  logic [IW-1:0] ngrp, cnt_inc;

  assign ngrp    = {2'b00, vl_q[IW-1:2]};
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vl_d   = vl_q;
    cap_d  = cap_q;
    agn_d  = agn_q;
    err_d  = err_q;
    wide_d = wide_q;
    hi_d   = hi_q;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          vl_d   = vl;
          cap_d  = cap;
          agn_d  = agn_in;
          wide_d = wide_in;
          hi_d   = hi_in;
          if (vl[1:0] != 2'b00) begin
            err_d = 1'b1;
            st_d  = S_FIN;
          end else if (vstart[IW-1:2] < vl[IW-1:2]) begin
            cnt_d = {2'b00, vstart[IW-1:2]};
            st_d  = S_RUN;
          end else if (agn_in && (vl < cap)) begin
            cnt_d = vl;
            st_d  = S_FILL;
          end else begin
            st_d = S_FIN;
          end
        end
      end
      S_RUN: begin
        if (cnt_inc != ngrp) begin
          cnt_d = cnt_inc;
        end else if (agn_q && (vl_q < cap_q)) begin
          cnt_d = vl_q;
          st_d  = S_FILL;
        end else begin
          st_d = S_FIN;
        end
      end
      S_FILL: begin
        if (cnt_inc != cap_q) cnt_d = cnt_inc;
        else                  st_d  = S_FIN;
      end
      default: begin
        err_d = 1'b0;
        st_d  = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      vl_q   <= '0;
      cap_q  <= '0;
      agn_q  <= 1'b0;
      err_q  <= 1'b0;
      wide_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      vl_q   <= vl_d;
      cap_q  <= cap_d;
      agn_q  <= agn_d;
      err_q  <= err_d;
      wide_q <= wide_d;
      hi_q   <= hi_d;
    end
  end

  assign grp_en     = (st_q == S_RUN);
  assign tail_en    = (st_q == S_FILL);
  assign busy       = grp_en | tail_en;
  assign done       = (st_q == S_FIN);
  assign illegal    = done & err_q;
  assign clr_vstart = done & ~err_q;
  assign grp_idx    = cnt_q[IW-3:0];
  assign tail_idx   = cnt_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_grp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en && $past(grp_en)) |-> (grp_idx == $past(grp_idx) + 1'b1));
  p_tail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_en && $past(tail_en)) |-> (tail_idx == $past(tail_idx) + 1'b1));
  p_tail_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tail_en |-> (agn_q && tail_idx >= vl_q && tail_idx < cap_q));
  p_grp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_en |-> ({2'b00, grp_idx} < ngrp));
  p_bad_vl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == S_IDLE && vl[1:0] != 2'b00) |=> (illegal && !grp_en && !tail_en));
endmodule

// File: rtl/sha2_vcompress.sv
module sha2_vcompress
  import sha2vc_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                sew64,
  input  logic                hi_words,
  input  logic                tail_agn,
  input  logic [IW-1:0]       vl,
  input  logic [IW-1:0]       vstart,
  input  logic [IW-1:0]       cap,
  input  logic [NLANE*LW-1:0] src2_grp,
  input  logic [NLANE*LW-1:0] dst_grp,
  input  logic [NLANE*LW-1:0] sched_grp,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic                vstart_clr,
  output logic [IW-3:0]       grp_idx,
  output logic                wr_en,
  output logic [NLANE*LW-1:0] wr_data,
  output logic                tail_en,
  output logic [IW-1:0]       tail_idx,
  output logic [LW-1:0]       tail_data
);
  logic wide_q, hi_q;

  sha2_seq #(.IW(IW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wide_in    (sew64),
    .hi_in      (hi_words),
    .agn_in     (tail_agn),
    .vl         (vl),
    .vstart     (vstart),
    .cap        (cap),
    .wide_q     (wide_q),
    .hi_q       (hi_q),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .clr_vstart (vstart_clr),
    .grp_en     (wr_en),
    .grp_idx    (grp_idx),
    .tail_en    (tail_en),
    .tail_idx   (tail_idx)
  );

  sha2_two_round u_dp (
    .wide      (wide_q),
    .hi_sel    (hi_q),
    .half_abef (src2_grp),
    .half_cdgh (dst_grp),
    .sched     (sched_grp),
    .result    (wr_data)
  );

  assign tail_data = wide_q ? {LW{1'b1}} : {{(LW/2){1'b0}}, {(LW/2){1'b1}}};

  p_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide_q) |-> (wr_data[LW-1:LW/2] == '0 && wr_data[2*LW-1:LW+LW/2] == '0 &&
                            wr_data[3*LW-1:2*LW+LW/2] == '0 && wr_data[4*LW-1:3*LW+LW/2] == '0));
  p_one_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && tail_en));
  p_clr_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> (done && !illegal));
endmodule

// File: tb/sha2_vcompress_test.sv
module sha2_vcompress_test;
  localparam int IW = 6;
  localparam int NE = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sew64 = 1'b0, hi_words = 1'b0, tail_agn = 1'b0;
  logic [IW-1:0] vl = '0, vstart = '0, cap = '0;
  logic [255:0] src2_grp, dst_grp, sched_grp, wr_data;
  logic busy, done, illegal, vstart_clr, wr_en, tail_en;
  logic [IW-3:0] grp_idx;
  logic [IW-1:0] tail_idx;
  logic [63:0] tail_data;

  logic [63:0] m_src2 [NE];
  logic [63:0] m_dst  [NE];
  logic [63:0] m_sch  [NE];
  logic [63:0] m_exp  [NE];

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5ns clk = ~clk;

  sha2_vcompress #(.IW(IW)) uut (.*);

  assign src2_grp  = {m_src2[grp_idx*4+3], m_src2[grp_idx*4+2], m_src2[grp_idx*4+1], m_src2[grp_idx*4]};
  assign dst_grp   = {m_dst[grp_idx*4+3],  m_dst[grp_idx*4+2],  m_dst[grp_idx*4+1],  m_dst[grp_idx*4]};
  assign sched_grp = {m_sch[grp_idx*4+3],  m_sch[grp_idx*4+2],  m_sch[grp_idx*4+1],  m_sch[grp_idx*4]};

  always @(posedge clk) begin
    if (wr_en)
      for (int k = 0; k < 4; k++) m_dst[grp_idx*4+k] <= wr_data[k*64 +: 64];
    if (tail_en) m_dst[tail_idx] <= tail_data;
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ror(input logic [63:0] x, input int n, input bit w64);
    logic [31:0] lo;
    if (w64) return (x >> n) | (x << (64 - n));
    lo = (x[31:0] >> n) | (x[31:0] << (32 - n));
    return {32'h0, lo};
  endfunction

  // behavioural reference: two rounds, returns {a,b,e,f} lanes 3..0
  function automatic logic [255:0] ref_grp(input bit w64, input bit hi, input int g);
    logic [63:0] m, a, b, c, d, e, f, h, gg, s0, s1, t1, t2, w;
    m = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a = m_src2[g*4+3] & m; b = m_src2[g*4+2] & m; e = m_src2[g*4+1] & m; f = m_src2[g*4] & m;
    c = m_dst[g*4+3] & m;  d = m_dst[g*4+2] & m;  gg = m_dst[g*4+1] & m; h = m_dst[g*4] & m;
    for (int r = 0; r < 2; r++) begin
      w  = m_sch[g*4 + (hi ? 2 : 0) + r] & m;
      s1 = w64 ? (ror(e,14,1) ^ ror(e,18,1) ^ ror(e,41,1)) : (ror(e,6,0) ^ ror(e,11,0) ^ ror(e,25,0));
      s0 = w64 ? (ror(a,28,1) ^ ror(a,34,1) ^ ror(a,39,1)) : (ror(a,2,0) ^ ror(a,13,0) ^ ror(a,22,0));
      t1 = (h + s1 + ((e & f) ^ (~e & gg)) + w) & m;
      t2 = (s0 + ((a & b) ^ (a & c) ^ (b & c))) & m;
      h = gg; gg = f; f = e; e = (d + t1) & m; d = c; c = b; b = a; a = (t1 + t2) & m;
    end
    return {a, b, e, f};
  endfunction

  task automatic run_op(input bit w64, input bit hi, input bit agn, input int nvl, input int nvs,
                        input int ncap, input string req);
    logic [255:0] exp;
    logic [63:0] fill;
    bit legal;
    for (int i = 0; i < NE; i++) begin
      m_src2[i] = {$urandom, $urandom};
      m_dst[i]  = {$urandom, $urandom};
      m_sch[i]  = {$urandom, $urandom};
      m_exp[i]  = m_dst[i];
    end
    legal = (nvl % 4) == 0;
    fill  = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (legal) begin
      for (int g = nvs / 4; g < nvl / 4; g++) begin
        exp = ref_grp(w64, hi, g);
        for (int k = 0; k < 4; k++) m_exp[g*4+k] = exp[k*64 +: 64];
      end
      if (agn) for (int i = nvl; i < ncap; i++) m_exp[i] = fill;
    end
    sew64 = w64; hi_words = hi; tail_agn = agn;
    vl = IW'(nvl); vstart = IW'(nvs); cap = IW'(ncap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (legal) begin
      for (int g = nvs / 4; g < nvl / 4; g++) begin
        exp = ref_grp(w64, hi, g);
        chk(wr_en && busy && !tail_en && grp_idx == (IW-2)'(g), {req, " R6 group step"},
            {wr_en, busy, grp_idx}, {2'b11, (IW-2)'(g)});
        chk(wr_data == exp, {req, " R1 R2 R3 R4 R10 group data"}, wr_data, exp);
        @(negedge clk);
      end
      if (agn) begin
        for (int i = nvl; i < ncap; i++) begin
          chk(tail_en && busy && !wr_en && tail_idx == IW'(i) && tail_data == fill,
              {req, " R7 R10 tail fill"}, {tail_en, busy, tail_idx, tail_data}, {2'b11, IW'(i), fill});
          @(negedge clk);
        end
      end
    end
    chk(done && !busy && !wr_en && !tail_en && illegal == !legal && vstart_clr == legal,
        {req, " R5 R7 R8 completion"}, {done, busy, wr_en, tail_en, illegal, vstart_clr},
        {1'b1, 3'b000, !legal, legal});
    @(negedge clk);
    chk(!done && !illegal && !vstart_clr && !busy, {req, " R8 done single pulse"},
        {done, illegal, vstart_clr, busy}, 4'b0000);
    for (int i = 0; i < NE; i++)
      chk(m_dst[i] == m_exp[i], {req, " R5 R6 R7 destination contents"}, m_dst[i], m_exp[i]);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !wr_en && !tail_en, "R9 in reset",
        {busy, done, illegal, wr_en, tail_en}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !illegal && !wr_en && !tail_en, "R9 after reset",
        {busy, done, illegal, wr_en, tail_en}, 5'b0);
    run_op(1'b0, 1'b0, 1'b1, 8,  0, 16, "R1 R3 sha256 low words");
    run_op(1'b0, 1'b1, 1'b0, 12, 4, 16, "R1 R3 sha256 high words vstart");
    run_op(1'b1, 1'b0, 1'b0, 8,  0, 8,  "R2 R3 sha512 low words");
    run_op(1'b1, 1'b1, 1'b1, 16, 9, 22, "R2 R7 sha512 high words odd cap");
    run_op(1'b0, 1'b0, 1'b1, 6,  0, 16, "R5 bad vl tail agnostic");
    run_op(1'b1, 1'b1, 1'b0, 13, 4, 16, "R5 bad vl");
    run_op(1'b0, 1'b1, 1'b1, 4,  4, 10, "R6 empty range with fill");
    run_op(1'b1, 1'b0, 1'b0, 8,  12, 16, "R6 vstart past end");
    run_op(1'b0, 1'b0, 1'b0, 60, 0, 63, "R1 R6 long vector");
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule